// File: doc/BRIEF.md
# FP/GP Register Move Execute Unit

This unit decodes and executes raw bit-pattern moves between a 32-entry, 64-bit general register file and a 32-entry, 128-bit vector register file. No numeric conversion takes place. Each move copies a half, single or double sized field in either direction. One form reaches the upper 64-bit half of a vector register. The unit takes one 32-bit instruction word per valid strobe. It reads its source through combinational read ports into register files that live outside it, and it issues at most one registered write one clock later.

Each word is checked against a fixed pattern. A word that does not match is not a move and is ignored. A matching word can still be an undefined encoding, for example because of a size mismatch, a missing half-precision feature, or an illegal upper-lane combination. In that case no register is written and a one-cycle undefined pulse is raised. A defined move issued while the floating-point disable input is high also writes nothing, and raises a separate one-cycle pulse.

Top module: `fpgp_move_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both write enables and both pulse outputs are low, whatever the other inputs are.
- R2: A word is a move only when bits 30:24 = 0011110, bit 21 = 1, bits 15:10 = 0, bits 18:17 = 11 and bit 20 = 0. Any other word, or any word presented with `in_valid` low, produces no write and no pulse.
- R3: The general operand is 32 bits when bit 31 (sf) is 0 and 64 bits when it is 1. The vector field size comes from the type field, bits 23:22: 00 gives 32, 01 gives 64, 10 gives 64 and 11 gives 16.
- R4: Four encodings are undefined: (a) type 10 with bit 19 = 0; (b) type 11 while `half_ok` is low; (c) bit 19 = 0 with a field size that is neither 16 nor equal to the general operand size; (d) bit 19 = 1 unless sf = 1 and type = 10. An undefined word raises `undef_pulse` for exactly one cycle, one clock after the word is accepted, and causes no write.
- R5: A defined move accepted while `fp_off` is high raises `fp_off_pulse` for one cycle and causes no write. An undefined word raises only `undef_pulse`, even when `fp_off` is high.
- R6: In the vector-to-general direction, the selected field of vector register Rn (bits 9:5) is zero-extended to 64 bits and written to general register Rd (bits 4:0) one clock after acceptance.
- R7: In the general-to-vector direction with lane 0, vector register Rd is written with the low field-size bits of general register Rn, and all bits above the field size are cleared.
- R8: The upper-lane general-to-vector move replaces bits 127:64 of vector register Rd with the 64-bit general source and keeps bits 63:0 of Rd unchanged.
- R9: The upper-lane vector-to-general move reads bits 127:64 of vector register Rn.
- R10: General register index 31 reads as zero, and a write aimed at it is dropped with no pulse.
- R11: Opcode bit 16 selects the direction: 1 moves general to vector, 0 moves vector to general.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is presented this cycle |
| in_word | input | 32 | Instruction word |
| half_ok | input | 1 | Half-precision support is present |
| fp_off | input | 1 | Floating-point access disabled |
| gp_raddr | output | 5 | General register read address (Rn) |
| gp_rdata | input | 64 | General register read data |
| vr_raddr | output | 5 | Vector register read address (Rn, or Rd for general-to-vector) |
| vr_rdata | input | 128 | Vector register read data |
| gp_we | output | 1 | General register write enable |
| gp_waddr | output | 5 | General register write address |
| gp_wdata | output | 64 | General register write data |
| vr_we | output | 1 | Vector register write enable |
| vr_waddr | output | 5 | Vector register write address |
| vr_wdata | output | 128 | Vector register full write data |
| undef_pulse | output | 1 | Undefined encoding seen |
| fp_off_pulse | output | 1 | Defined move blocked by disable |

## Verification
Every decision is made in one cycle and registered once, so any decode fault shows at the ports on the clock after the word is accepted. Such a fault would be a wrong size, a wrong lane or a wrong undefined class. It appears either as the wrong one of the four outcome signals or as a write data word whose high bits are not cleared or whose untouched half has changed. A pulse that is stuck or a write that repeats shows on the following idle cycle. The stimulus therefore covers every legal form, every illegal combination of type, lane and sf, and the priority between the two pulses.

// File: rtl/fmv_pkg.sv
package fmv_pkg;
  localparam int RA_W = 5;

  typedef enum logic [1:0] {
    FSZ_H = 2'd0,
    FSZ_S = 2'd1,
    FSZ_D = 2'd2
  } fsz_e;

  typedef struct packed {
    logic            hit;
    logic            bad;
    logic            to_fp;
    logic            lane_hi;
    logic            int64;
    fsz_e            fsz;
    logic [RA_W-1:0] rn;
    logic [RA_W-1:0] rd;
  } dec_t;

  // Field size from the type bits via the XOR rule; type 10 is a special 64.
  function automatic fsz_e size_of_type(input logic [1:0] ft);
    logic [1:0] x;
    x = ft ^ 2'b10;
    if (ft == 2'b10) return FSZ_D;
    case (x)
      2'b01:   return FSZ_H;
      2'b10:   return FSZ_S;
      default: return FSZ_D;
    endcase
  endfunction
endpackage

// File: rtl/fmv_decode.sv
module fmv_decode
  import fmv_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] word,
  input  logic          half_ok,
  output dec_t          dec
);
  logic       sf;
  logic [1:0] ft;
  logic [1:0] rm;
  logic [2:0] op;
  fsz_e       fs;
  logic       size_ok;

  assign sf = word[31];
  assign ft = word[23:22];
  assign rm = word[20:19];
  assign op = word[18:16];
  assign fs = size_of_type(ft);

  // Half is legal with either general width; others must match it.
  always_comb begin
    case (fs)
      FSZ_H:   size_ok = 1'b1;
      FSZ_S:   size_ok = !sf;
      default: size_ok = sf;
    endcase
  end

  always_comb begin
    dec.hit     = (word[30:24] == 7'b0011110) && word[21] &&
                  (word[15:10] == 6'd0) && (op[2:1] == 2'b11) && !rm[1];
    dec.bad     = ((ft == 2'b10) && !rm[0]) ||
                  ((ft == 2'b11) && !half_ok) ||
                  (!rm[0] && !size_ok) ||
                  (rm[0] && (!sf || ft != 2'b10));
    dec.to_fp   = op[0];
    dec.lane_hi = rm[0];
    dec.int64   = sf;
    dec.fsz     = fs;
    dec.rn      = word[9:5];
    dec.rd      = word[4:0];
  end
endmodule

// File: rtl/fmv_datapath.sv
module fmv_datapath
  import fmv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VLEN = 2 * XLEN
) (
  input  dec_t            dec,
  input  logic [XLEN-1:0] gp_src,
  input  logic [VLEN-1:0] vr_src,
  output logic [XLEN-1:0] gp_val,
  output logic [VLEN-1:0] vr_val
);
  localparam int HI_W = VLEN - XLEN;

  logic [XLEN-1:0] fmask;
  logic [XLEN-1:0] lane_val;

  always_comb begin
    case (dec.fsz)
      FSZ_H:   fmask = {XLEN{1'b1}} >> (XLEN - 16);
      FSZ_S:   fmask = {XLEN{1'b1}} >> (XLEN - 32);
      default: fmask = {XLEN{1'b1}} >> (XLEN - 64);
    endcase
  end

  assign lane_val = dec.lane_hi ? vr_src[VLEN-1:XLEN] : vr_src[XLEN-1:0];
  assign gp_val   = lane_val & fmask;

  // Upper lane merges with the old low half; lane 0 clears everything above.
  always_comb begin
    if (dec.lane_hi) vr_val = {gp_src[HI_W-1:0], vr_src[XLEN-1:0]};
    else             vr_val = {{HI_W{1'b0}}, gp_src & fmask};
  end
endmodule

// File: rtl/fpgp_move_unit.sv
module fpgp_move_unit
  import fmv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VLEN = 2 * XLEN,
  parameter int IW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IW-1:0]   in_word,
  input  logic            half_ok,
  input  logic            fp_off,
  output logic [RA_W-1:0] gp_raddr,
  input  logic [XLEN-1:0] gp_rdata,
  output logic [RA_W-1:0] vr_raddr,
  input  logic [VLEN-1:0] vr_rdata,
  output logic            gp_we,
  output logic [RA_W-1:0] gp_waddr,
  output logic [XLEN-1:0] gp_wdata,
  output logic            vr_we,
  output logic [RA_W-1:0] vr_waddr,
  output logic [VLEN-1:0] vr_wdata,
  output logic            undef_pulse,
  output logic            fp_off_pulse
);
  localparam logic [RA_W-1:0] ZR = {RA_W{1'b1}};

  dec_t            dec;
  logic [XLEN-1:0] gp_src;
  logic [XLEN-1:0] gp_val;
  logic [VLEN-1:0] vr_val;
  logic            take;
  logic            go;

  fmv_decode #(.IW(IW)) u_dec (
    .word    (in_word),
    .half_ok (half_ok),
    .dec     (dec)
  );

  assign gp_raddr = dec.rn;
  assign vr_raddr = dec.to_fp ? dec.rd : dec.rn;
  assign gp_src   = (dec.rn == ZR) ? '0 : gp_rdata;

  fmv_datapath #(.XLEN(XLEN), .VLEN(VLEN)) u_dp (
    .dec    (dec),
    .gp_src (gp_src),
    .vr_src (vr_rdata),
    .gp_val (gp_val),
    .vr_val (vr_val)
  );

  assign take = in_valid && dec.hit;
  assign go   = take && !dec.bad && !fp_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      gp_we        <= 1'b0;
      vr_we        <= 1'b0;
      undef_pulse  <= 1'b0;
      fp_off_pulse <= 1'b0;
    end else begin
      gp_we        <= go && !dec.to_fp && (dec.rd != ZR);
      vr_we        <= go && dec.to_fp;
      undef_pulse  <= take && dec.bad;
      fp_off_pulse <= take && !dec.bad && fp_off;
    end
  end

  always_ff @(posedge clk) begin
    gp_waddr <= dec.rd;
    gp_wdata <= gp_val;
    vr_waddr <= dec.rd;
    vr_wdata <= vr_val;
  end

  // R4 R5
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gp_we, vr_we, undef_pulse, fp_off_pulse}));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (gp_we || vr_we || undef_pulse || fp_off_pulse) |-> $past(in_valid));

  // R10
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    gp_we |-> (gp_waddr != ZR));

  // R8
  lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (vr_we && $past(dec.lane_hi)) |-> (vr_wdata[XLEN-1:0] == $past(vr_rdata[XLEN-1:0])));

  // R7
  lane_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (vr_we && !$past(dec.lane_hi)) |-> (vr_wdata[VLEN-1:XLEN] == '0));

  // R3
  gp_size_chk: assert property (@(posedge clk) disable iff (rst)
    (gp_we && $past(!dec.int64)) |-> (gp_wdata[XLEN-1:32] == '0));
endmodule

// File: tb/sim_fpgp_move_unit.sv
module sim_fpgp_move_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  in_word = '0;
  logic         half_ok = 1'b1;
  logic         fp_off = 1'b0;
  logic [4:0]   gp_raddr, vr_raddr, gp_waddr, vr_waddr;
  logic [63:0]  gp_rdata, gp_wdata;
  logic [127:0] vr_rdata, vr_wdata;
  logic         gp_we, vr_we, undef_pulse, fp_off_pulse;

  logic [63:0]  gpr [32];
  logic [127:0] vrf [32];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign gp_rdata = gpr[gp_raddr];
  assign vr_rdata = vrf[vr_raddr];

  fpgp_move_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .half_ok(half_ok), .fp_off(fp_off),
    .gp_raddr(gp_raddr), .gp_rdata(gp_rdata),
    .vr_raddr(vr_raddr), .vr_rdata(vr_rdata),
    .gp_we(gp_we), .gp_waddr(gp_waddr), .gp_wdata(gp_wdata),
    .vr_we(vr_we), .vr_waddr(vr_waddr), .vr_wdata(vr_wdata),
    .undef_pulse(undef_pulse), .fp_off_pulse(fp_off_pulse)
  );

  function automatic logic [31:0] mk(input logic sf, input logic [1:0] ft,
      input logic [1:0] rm, input logic [2:0] op, input logic [4:0] rn, input logic [4:0] rd);
    return {sf, 7'b0011110, ft, 1'b1, rm, op, 6'd0, rn, rd};
  endfunction

  // kinds: 0 none, 1 general write, 2 vector write, 3 undefined, 4 disabled
  function automatic logic [36:0] e(input logic [31:0] w, input logic h, input logic o,
      input logic [2:0] k);
    return {w, h, o, k};
  endfunction

  localparam int NV = 25;
  localparam logic [36:0] VT [NV] = '{
    e(mk(0, 2'b00, 2'b00, 3'b110, 5'd3, 5'd5), 1, 0, 3'd1),
    e(mk(0, 2'b00, 2'b00, 3'b111, 5'd4, 5'd6), 1, 0, 3'd2),
    e(mk(1, 2'b01, 2'b00, 3'b110, 5'd7, 5'd8), 1, 0, 3'd1),
    e(mk(1, 2'b01, 2'b00, 3'b111, 5'd9, 5'd10), 1, 0, 3'd2),
    e(mk(0, 2'b11, 2'b00, 3'b110, 5'd1, 5'd2), 1, 0, 3'd1),
    e(mk(1, 2'b11, 2'b00, 3'b110, 5'd15, 5'd16), 1, 0, 3'd1),
    e(mk(0, 2'b11, 2'b00, 3'b111, 5'd17, 5'd18), 1, 0, 3'd2),
    e(mk(1, 2'b11, 2'b00, 3'b111, 5'd19, 5'd20), 1, 0, 3'd2),
    e(mk(1, 2'b10, 2'b01, 3'b111, 5'd11, 5'd12), 1, 0, 3'd2),
    e(mk(1, 2'b10, 2'b01, 3'b110, 5'd13, 5'd14), 1, 0, 3'd1),
    e(mk(0, 2'b11, 2'b00, 3'b110, 5'd1, 5'd2), 0, 0, 3'd3),
    e(mk(1, 2'b10, 2'b00, 3'b110, 5'd1, 5'd2), 1, 0, 3'd3),
    e(mk(0, 2'b01, 2'b00, 3'b110, 5'd1, 5'd2), 1, 0, 3'd3),
    e(mk(1, 2'b00, 2'b00, 3'b111, 5'd1, 5'd2), 1, 0, 3'd3),
    e(mk(0, 2'b10, 2'b01, 3'b111, 5'd1, 5'd2), 1, 0, 3'd3),
    e(mk(1, 2'b00, 2'b01, 3'b111, 5'd1, 5'd2), 1, 0, 3'd3),
    e(mk(1, 2'b11, 2'b01, 3'b110, 5'd1, 5'd2), 1, 0, 3'd3),
    e(mk(1, 2'b01, 2'b01, 3'b110, 5'd1, 5'd2), 1, 0, 3'd3),
    e(mk(1, 2'b01, 2'b00, 3'b110, 5'd1, 5'd2), 1, 1, 3'd4),
    e(mk(0, 2'b11, 2'b00, 3'b110, 5'd1, 5'd2), 0, 1, 3'd3),
    e(mk(1, 2'b01, 2'b00, 3'b110, 5'd1, 5'd2) & ~32'h0020_0000, 1, 0, 3'd0),
    e(mk(1, 2'b01, 2'b10, 3'b110, 5'd1, 5'd2), 1, 0, 3'd0),
    e(mk(1, 2'b01, 2'b00, 3'b100, 5'd1, 5'd2), 1, 0, 3'd0),
    e(mk(1, 2'b01, 2'b00, 3'b110, 5'd2, 5'd31), 1, 0, 3'd0),
    e(mk(1, 2'b01, 2'b00, 3'b111, 5'd31, 5'd3), 1, 0, 3'd2)
  };

  function automatic logic [63:0] fmask(input logic [1:0] ft);
    case (ft)
      2'b11:   return 64'h0000_0000_0000_FFFF;
      2'b00:   return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
      input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic h, input logic o);
    @(negedge clk);
    in_word  = w;
    half_ok  = h;
    fp_off   = o;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_kind(input logic [2:0] k, input string req);
    logic [3:0] act, exp;
    act = {gp_we, vr_we, undef_pulse, fp_off_pulse};
    exp = {k == 3'd1, k == 3'd2, k == 3'd3, k == 3'd4};
    chk(act == exp, req, 128'(act), 128'(exp));
  endtask

  task automatic check_data(input logic [31:0] w, input logic [2:0] k, input string req);
    logic [4:0]   rn, rd;
    logic [63:0]  g, ex;
    logic [127:0] vx;
    rn = w[9:5];
    rd = w[4:0];
    if (k == 3'd1) begin
      ex = (w[19] ? vrf[rn][127:64] : vrf[rn][63:0]) & fmask(w[23:22]);
      chk(gp_waddr == rd && gp_wdata == ex, req, {gp_waddr, gp_wdata}, {rd, ex});
    end else if (k == 3'd2) begin
      g  = (rn == 5'd31) ? 64'd0 : gpr[rn];
      vx = w[19] ? {g, vrf[rd][63:0]} : {64'd0, g & fmask(w[23:22])};
      chk(vr_waddr == rd && vr_wdata == vx, req, vr_wdata, vx);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      gpr[i] = {32'hC0DE_0000 + 32'(i), 32'h8765_4300 + 32'(i * 7)};
      vrf[i] = {32'hAAAA_0000 + 32'(i), 32'h5555_1000 + 32'(i),
                32'h9999_2000 + 32'(i), 32'h7777_8000 + 32'(i * 3)};
    end

    // R1: outputs quiet while reset holds, even with a legal word valid
    in_word  = mk(1, 2'b01, 2'b00, 3'b110, 5'd1, 5'd2);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check_kind(3'd0, "R1");
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_kind(3'd0, "R1");

    for (int i = 0; i < NV; i++) begin
      issue(VT[i][36:5], VT[i][4], VT[i][3]);
      check_kind(VT[i][2:0], tag_of(VT[i][2:0]));
      check_data(VT[i][36:5], VT[i][2:0], tag_of(VT[i][2:0]));
    end

    // R2: legal word without the valid strobe does nothing
    @(negedge clk);
    in_word = mk(1, 2'b01, 2'b00, 3'b110, 5'd1, 5'd2);
    @(negedge clk);
    check_kind(3'd0, "R2");

    // R4: undefined pulse lasts one cycle only
    issue(mk(1, 2'b10, 2'b00, 3'b111, 5'd1, 5'd2), 1, 0);
    check_kind(3'd3, "R4");
    @(negedge clk);
    check_kind(3'd0, "R4");

    // R3: half field into 64-bit general register, upper 48 bits zero
    issue(mk(1, 2'b11, 2'b00, 3'b110, 5'd21, 5'd22), 1, 0);
    chk(gp_we && gp_wdata == {48'd0, vrf[21][15:0]}, "R3", 128'(gp_wdata),
        128'({48'd0, vrf[21][15:0]}));

    // R9: upper lane read gives bits 127:64
    issue(mk(1, 2'b10, 2'b01, 3'b110, 5'd23, 5'd24), 1, 0);
    chk(gp_we && gp_wdata == vrf[23][127:64], "R9", 128'(gp_wdata), 128'(vrf[23][127:64]));

    // R8: upper lane write keeps the low half of the destination
    issue(mk(1, 2'b10, 2'b01, 3'b111, 5'd25, 5'd26), 1, 0);
    chk(vr_we && vr_wdata == {gpr[25], vrf[26][63:0]}, "R8", vr_wdata,
        {gpr[25], vrf[26][63:0]});

    // R11: flipping only opcode bit 0 swaps the write port used
    issue(mk(0, 2'b00, 2'b00, 3'b111, 5'd5, 5'd6), 1, 0);
    check_kind(3'd2, "R11");
    issue(mk(0, 2'b00, 2'b00, 3'b110, 5'd5, 5'd6), 1, 0);
    check_kind(3'd1, "R11");

    // R10: zero register as destination is dropped, as source reads zero
    issue(mk(0, 2'b00, 2'b00, 3'b110, 5'd4, 5'd31), 1, 0);
    check_kind(3'd0, "R10");
    issue(mk(0, 2'b11, 2'b00, 3'b111, 5'd31, 5'd7), 1, 0);
    chk(vr_we && vr_wdata == '0, "R10", vr_wdata, 128'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule